// File: doc/BRIEF.md
# Multi-Channel Interrupt Fan-Out Multiplexer

This block collects a bank of level-sensitive, active-high interrupt sources and presents all of them to several independent output channels. Each channel holds its own enable mask. Its single interrupt output is asserted while any source that the mask lets through is high. Because every source reaches every channel, software can steer one source to any subset of the outputs by setting the same bit in several channel masks.

Software reaches the block through a plain register port. This port has a read strobe, a write strobe, a word address and a data bus as wide as the source bank. Channels sit on a 16-word stride. The mask register of a channel sits at word 4 of its slot and the read-only pending view at word 8. Source inputs are brought into the clock domain by a two-stage synchronizer before any masking. The port carries no streamed data, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `irq_fanout_mux`

## Requirements
- R1: After reset every channel mask reads zero, every interrupt output is low and `rd_data_o` is zero.
- R2: Channel n's mask register is at word address 16*n+4 (byte 0x40*n+0x10). A write there stores `wr_data_i`, and a later read returns exactly that value. Bit k enables source k.
- R3: Channel n's pending register is at word address 16*n+8 (byte 0x40*n+0x20). It reads as the synchronized sources ANDed with that channel's mask, with bit k standing for source k.
- R4: `irq_o[n]` is high exactly when channel n has at least one pending bit. A source change reaches the output on the third rising edge after the input changes: two synchronizer stages and one output register.
- R5: Writing zero to a channel's mask clears all of its pending bits. The channel's output drops on the second rising edge after the write strobe.
- R6: Writes to pending registers and to unmapped addresses change no mask. Unmapped addresses are slot words other than 4 and 8, and any slot index at or above the channel count.
- R7: Reads of unmapped addresses return zero.
- R8: Channels are independent. Changing one channel's mask never changes another channel's output.
- R9: Read data appears one clock after the read strobe and holds its value until the next read.
- R10: Sources are level-sensitive. A pending bit clears by itself once its source goes low, and no clearing write is needed.
- R11: One source enabled in several channel masks drives all of those channel outputs at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt sources, possibly asynchronous |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wr_data_i | input | NUM_SRC | Write data |
| rd_data_o | output | NUM_SRC | Registered read data |
| irq_o | output | NUM_CH | One level interrupt output per channel |

## Verification
The embedded assertions check on every cycle that the following hold:
- the synchronizer delays the sources by exactly two clocks;
- a channel mask changes only on a write that selects that channel, and then takes the written value;
- at most one channel is selected per write;
- unmapped reads yield zero, and read data holds between reads;
- an output stays low whenever its mask was zero on the previous cycle.

The bench scenarios cover the rest:
- the AND-of-mask view of the pending registers;
- the exact edge at which a source change reaches an output;
- routing of one source to several channels;
- the effect of one channel's mask on the other channels, which the bench observes at the output ports.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  // Each channel owns a slot of this many words in the register map.
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned SLOT_WORDS = 1 << SLOT_W;
  // Word positions inside a slot; software relies on these.
  localparam logic [SLOT_W-1:0] SLOT_MASK_WORD = 4'h4;
  localparam logic [SLOT_W-1:0] SLOT_PEND_WORD = 4'h8;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_MASK = 2'd1,
    REG_PEND = 2'd2
  } reg_kind_e;

  function automatic reg_kind_e slot_kind(input logic [SLOT_W-1:0] word);
    if (word == SLOT_MASK_WORD) return REG_MASK;
    if (word == SLOT_PEND_WORD) return REG_PEND;
    return REG_NONE;
  endfunction
endpackage

// File: rtl/irqmux_sync.sv
module irqmux_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // Cycles since reset, so the depth-2 check never looks before reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R4: the synchronized sources lag the raw inputs by exactly two edges.
  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/irqmux_channel.sv
module irqmux_channel #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NUM_SRC-1:0] load_data_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic               irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (load_i) mask_q <= load_data_i;
  end

  assign pend_o = src_i & mask_q;
  assign mask_o = mask_q;

  // Registered so the output never glitches while sources change.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= |pend_o;
  end

  assign irq_o = irq_q;

  // R2: a selected write lands in the mask on the next edge.
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (mask_q == $past(load_data_i)));

  // R6: with no write selecting this channel, the mask holds.
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mask_q));

  // R5: a zero mask means the output is low one edge later.
  p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_o);
endmodule

// File: rtl/irqmux_regs.sv
module irqmux_regs
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en_i,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NUM_CH-1:0][NUM_SRC-1:0]  masks_i,
  input  logic [NUM_CH-1:0][NUM_SRC-1:0]  pends_i,
  output logic [NUM_CH-1:0]               load_o,
  output logic [NUM_SRC-1:0]              rd_data_o
);
  localparam int unsigned CH_FIELD_W = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0]     slot_word;
  logic [CH_FIELD_W-1:0] ch_field;
  reg_kind_e             kind;
  logic [NUM_CH-1:0]     hit_mask;
  logic [NUM_CH-1:0]     hit_pend;
  logic [NUM_SRC-1:0]    rd_mux;
  logic [NUM_SRC-1:0]    rd_q;

  assign slot_word = addr_i[SLOT_W-1:0];
  assign ch_field  = addr_i[ADDR_W-1:SLOT_W];
  assign kind      = slot_kind(slot_word);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    logic ch_match;
    assign ch_match    = (ch_field == CH_FIELD_W'(c));
    assign hit_mask[c] = ch_match && (kind == REG_MASK);
    assign hit_pend[c] = ch_match && (kind == REG_PEND);
    assign load_o[c]   = wr_en_i && hit_mask[c];
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_mask[c]) rd_mux = masks_i[c];
      if (hit_pend[c]) rd_mux = pends_i[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  // R6: a write never selects more than one channel mask.
  p_one_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));

  // R6: writes to pending words never load a mask.
  p_pend_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != REG_MASK) |-> (load_o == '0));

  // R7: unmapped reads return zero.
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (hit_mask == '0) && (hit_pend == '0)) |=> (rd_data_o == '0));

  // R9: read data holds between reads.
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic [NUM_CH-1:0]  irq_o
);
  logic [NUM_SRC-1:0]              src_sync;
  logic [NUM_CH-1:0][NUM_SRC-1:0]  masks;
  logic [NUM_CH-1:0][NUM_SRC-1:0]  pends;
  logic [NUM_CH-1:0]               load;

  irqmux_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .sync_o  (src_sync)
  );

  irqmux_regs #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .masks_i   (masks),
    .pends_i   (pends),
    .load_o    (load),
    .rd_data_o (rd_data_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irqmux_channel #(.NUM_SRC(NUM_SRC)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load[c]),
      .load_data_i (wr_data_i),
      .src_i       (src_sync),
      .mask_o      (masks[c]),
      .pend_o      (pends[c]),
      .irq_o       (irq_o[c])
    );
  end

  // R1: the register map must fit every channel slot.
  initial begin
    p_map_fits_r1: assert ((NUM_CH * SLOT_WORDS) <= (1 << ADDR_W));
  end
endmodule

// File: tb/irq_fanout_mux_bench.sv
`timescale 1ns/1ps
module irq_fanout_mux_bench;
  localparam int NCH = 8;
  localparam int NSRC = 32;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            rd_en = 1'b0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [NSRC-1:0] wdata = '0;
  logic [NSRC-1:0] rdata;
  logic [NCH-1:0]  irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_fanout_mux #(.NUM_CH(NCH), .NUM_SRC(NSRC), .ADDR_W(AW)) u_irq_fanout_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .rd_en_i   (rd_en),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] mask;
    logic [31:0] srcv;
    logic [31:0] exp_pend;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b1},
    '{3'd3, 32'h0000_00F0, 32'h0000_000F, 32'h0000_0000, 1'b0},
    '{3'd7, 32'h8000_0000, 32'h8000_0001, 32'h8000_0000, 1'b1},
    '{3'd5, 32'hA5A5_0000, 32'hFFFF_FFFF, 32'hA5A5_0000, 1'b1},
    '{3'd2, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{3'd1, 32'h0F0F_0F0F, 32'h3C3C_3C3C, 32'h0C0C_0C0C, 1'b1}
  };

  function automatic logic [AW-1:0] mask_addr(input int ch);
    return AW'(16 * ch + 4);
  endfunction

  function automatic logic [AW-1:0] pend_addr(input int ch);
    return AW'(16 * ch + 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [NSRC-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [NSRC-1:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NSRC-1:0] v;
    settle(3);
    // R1: reset state seen at the ports.
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    rst_n = 1'b1;
    settle(2);
    for (int c = 0; c < NCH; c++) begin
      reg_read(mask_addr(c), v);
      check("R1 mask reset", v, 32'h0);
    end

    // Table walk: R2, R3, R4, R5, R8.
    for (int i = 0; i < 6; i++) begin
      reg_write(mask_addr(VECS[i].ch), VECS[i].mask);
      src = VECS[i].srcv;
      settle(4);
      reg_read(mask_addr(VECS[i].ch), v);
      check("R2 mask readback", v, VECS[i].mask);
      reg_read(pend_addr(VECS[i].ch), v);
      check("R3 pending", v, VECS[i].exp_pend);
      check("R4/R8 irq vector", 32'(irq), 32'(NCH'(VECS[i].exp_irq) << VECS[i].ch));
      reg_write(mask_addr(VECS[i].ch), '0);
      settle(1);
      check("R5 irq after zero mask", 32'(irq), 32'h0);
      src = '0;
      settle(3);
    end

    // R4: exact latency of a source edge to the output.
    reg_write(mask_addr(6), 32'h0000_0010);
    @(negedge clk);
    src = 32'h0000_0010;
    settle(2);
    check("R4 irq not yet after two edges", 32'(irq[6]), 32'h0);
    settle(1);
    check("R4 irq on third edge", 32'(irq[6]), 32'h1);

    // R5: output drops on the second edge after the zero write strobe.
    @(negedge clk);
    addr = mask_addr(6); wdata = '0; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5 irq still high one edge after write", 32'(irq[6]), 32'h1);
    @(negedge clk);
    check("R5 irq low two edges after write", 32'(irq[6]), 32'h0);
    src = '0;
    settle(3);

    // R6: writes to pending and unmapped words change no mask.
    reg_write(pend_addr(0), 32'hFFFF_FFFF);
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_write(8'h0C, 32'hFFFF_FFFF);
    reg_write(8'h84, 32'hFFFF_FFFF);
    reg_write(8'hF4, 32'hFFFF_FFFF);
    for (int c = 0; c < NCH; c++) begin
      reg_read(mask_addr(c), v);
      check("R6 mask untouched", v, 32'h0);
    end
    src = 32'hFFFF_FFFF;
    settle(4);
    check("R6 no irq after ignored writes", 32'(irq), 32'h0);

    // R7: unmapped reads return zero while real registers are non-zero.
    reg_write(mask_addr(0), 32'hFFFF_FFFF);
    settle(3);
    reg_read(8'h00, v);
    check("R7 read word 0", v, 32'h0);
    reg_read(8'h0C, v);
    check("R7 read word 0x0C", v, 32'h0);
    reg_read(8'h84, v);
    check("R7 read beyond channels", v, 32'h0);

    // R9: read data one clock after the strobe, then held.
    reg_read(pend_addr(0), v);
    check("R9 read data after one clock", v, 32'hFFFF_FFFF);
    src = '0;
    settle(5);
    check("R9 read data held", rdata, 32'hFFFF_FFFF);
    reg_write(mask_addr(0), '0);

    // R10: pending clears when the source drops, no clear write.
    reg_write(mask_addr(4), 32'h0000_0008);
    src = 32'h0000_0008;
    settle(4);
    check("R10 irq while source high", 32'(irq[4]), 32'h1);
    src = '0;
    settle(4);
    check("R10 irq after source low", 32'(irq[4]), 32'h0);
    reg_read(pend_addr(4), v);
    check("R10 pending after source low", v, 32'h0);
    reg_write(mask_addr(4), '0);

    // R11 and R8: one source routed to two channels, then one unrouted.
    reg_write(mask_addr(1), 32'h0000_0200);
    reg_write(mask_addr(6), 32'h0000_0200);
    src = 32'h0000_0200;
    settle(4);
    check("R11 source on two channels", 32'(irq), 32'h42);
    reg_write(mask_addr(1), '0);
    settle(2);
    check("R8 other channel unaffected", 32'(irq), 32'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule